// File: doc/BRIEF.md
# NRZI Tape Record Write Formatter

This block turns a stream of host bytes into the character sequence of one NRZI tape record. It runs in either 7-track or 9-track mode. A record starts with a start pulse. The block then raises a data flag to ask the host for the next byte. The host answers with an acknowledge strobe that loads the byte into a holding register. On the next character-rate clock enable, the byte goes out on the write bus with its parity bit added.

When the host asserts halt, the block stops asking for bytes and writes the trailer on its own. In 9-track mode the trailer is a cyclic check character followed by a longitudinal check character. In 7-track mode the trailer is the longitudinal character only. Each trailer character is preceded by a fixed run of blank character periods.

A second start input writes a file-mark record instead of a data record. That record is one fixed mark character followed by the same trailer. A done pulse marks the end of every record. All tape-side lines are active low, so an idle line sits high.

Top module: `tapefmt_writer`

## Requirements
- R1: After reset, dataFlag, writeStrobe and done are low, and every write line (writeDataN and writeParN) is high.
- R2: Parity. In 9-track mode every data and mark character carries odd parity over its 9 bits. In 7-track mode the parity is odd when oddParity7=1 and even when oddParity7=0. In 7-track mode channels 0 and 1 are always written as 0.
- R3: Channel k of the write bus (writeDataN[k]) carries host bit hostData[7-k], so channel 0 is the most significant bit. writeParN carries the parity bit. All of these lines are inverted: a 1 is driven low.
- R4: Handshake.
  - dataFlag rises the cycle after a start, and again the cycle after each data strobe.
  - An acknowledge while dataFlag is high loads hostData and clears dataFlag on the next cycle.
  - A loaded byte is written at the next charEn.
  - writeStrobe is high only in the cycle after a charEn cycle.
- R5: Halt.
  - While hostHalt is high, dataFlag is low from the next cycle on and no further bytes are requested.
  - A byte already loaded is still written.
  - The first charEn that finds the holding register empty with halt high counts as blank period 1 of the trailer gap.
- R6: 9-track trailer. The last data or mark character is followed by GAP_CHARS (4) blank charEn periods, then the cyclic check character. After that come 4 more blank periods, then the longitudinal check character.
- R7: 7-track trailer. No cyclic check character is written. The longitudinal check character follows 4 blank charEn periods after the last character.
- R8: Each bit of the longitudinal check character, parity track included, makes the count of ones in that track across the whole record even. In 9-track mode the count includes the cyclic check character.
- R9: The cyclic check character is derived from a 9-bit register, called crc below.
  - The register is cleared at record start.
  - Per character, with vector v (bit k = channel k, bit 8 = parity): t = crc ^ v, then crc = {t[7:0],0} ^ (t[8] ? 0x079 : 0).
  - The value written is crc ^ 0x1EB, which inverts every bit except 2 and 4.
- R10: File marks.
  - A 9-track mark has ones in channels 3, 6 and 7. Its cyclic check character is all zeros and its longitudinal check character equals the mark.
  - A 7-track mark, or a 9-track mark with specialMark9=1, has ones in channels 4 to 7.
  - Mark parity follows R2.
- R11: done is a single-cycle pulse in the cycle after the first charEn cycle that follows the longitudinal check strobe's charEn.
- R12: A start pulse received while a record is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| charEn | input | 1 | Character-rate enable, one cycle per character period |
| nineTrack | input | 1 | 1 = 9-track rules, 0 = 7-track rules (latched at start) |
| oddParity7 | input | 1 | 7-track parity select, 1 = odd (latched at start) |
| specialMark9 | input | 1 | Write the 7-track mark code in 9-track mode (latched at start) |
| startWrite | input | 1 | Start a data record (pulse) |
| startMark | input | 1 | Start a file-mark record (pulse) |
| dataFlag | output | 1 | Request for the next host byte |
| hostAck | input | 1 | Acknowledge strobe, loads hostData |
| hostData | input | 8 | Host byte, bit 7 most significant |
| hostHalt | input | 1 | End of data; trailer follows |
| writeDataN | output | 8 | Channel lines 0..7, active low |
| writeParN | output | 1 | Parity line, active low |
| writeStrobe | output | 1 | Write strobe, high for one cycle per character |
| done | output | 1 | End-of-record pulse |

## Verification
Each character leaves the block one clock after the charEn cycle that selects it. The bench therefore counts charEn periods and samples on the falling edge that follows each such cycle. It tags every captured character with the period number and checks the trailer spacing as a difference in periods from the first character. The flag's response to an acknowledge or a halt is due one clock later and is checked on the next falling edge. The done pulse is expected exactly one period after the longitudinal character. Records of several lengths are swept across both track modes, both 7-track parities and every file-mark variant. The expected characters, check characters and positions are all computed arithmetically in the bench.

// File: rtl/tapefmt_pkg.sv
`timescale 1ns/1ps
package tapefmt_pkg;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_MARK = 2'd1,
    SRC_CRCC = 2'd2,
    SRC_LRCC = 2'd3
  } charSrc_t;

  typedef struct packed {
    logic     startRec;
    logic     loadHold;
    logic     emit;
    charSrc_t src;
  } ctrlStrobe_t;

  typedef struct packed {
    logic nine;
    logic oddSel;
    logic special;
    logic mark;
  } recCfg_t;

endpackage

// File: rtl/tapefmt_ctrl.sv
`timescale 1ns/1ps
module tapefmt_ctrl
  import tapefmt_pkg::*;
#(
  parameter int GAP_CHARS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        charEn,
  input  logic        nineTrack,
  input  logic        oddParity7,
  input  logic        specialMark9,
  input  logic        startWrite,
  input  logic        startMark,
  input  logic        hostAck,
  input  logic        hostHalt,
  input  logic        holdFull,
  output logic        dataFlag,
  output logic        done,
  output ctrlStrobe_t strb,
  output recCfg_t     cfg
);

  localparam int CW = $clog2(GAP_CHARS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DATA, ST_MARK, ST_GAP1, ST_GAP2, ST_FIN
  } ctrlState_t;

  ctrlState_t state, nextState;
  logic [CW-1:0] cnt, nextCnt;
  logic gapFull;

  assign gapFull = (cnt == CW'(GAP_CHARS));

  always_comb begin
    strb          = '0;
    strb.src      = SRC_DATA;
    strb.loadHold = hostAck & dataFlag;
    nextState     = state;
    nextCnt       = cnt;
    unique case (state)
      ST_IDLE: begin
        if (startWrite || startMark) begin
          strb.startRec = 1'b1;
          nextState     = startWrite ? ST_DATA : ST_MARK;
        end
      end
      ST_DATA: begin
        if (charEn) begin
          if (holdFull) begin
            strb.emit = 1'b1;
            strb.src  = SRC_DATA;
          end else if (hostHalt) begin
            nextState = ST_GAP1;
            nextCnt   = CW'(1);
          end
        end
      end
      ST_MARK: begin
        if (charEn) begin
          strb.emit = 1'b1;
          strb.src  = SRC_MARK;
          nextState = ST_GAP1;
          nextCnt   = '0;
        end
      end
      ST_GAP1: begin
        if (charEn) begin
          if (gapFull) begin
            strb.emit = 1'b1;
            strb.src  = cfg.nine ? SRC_CRCC : SRC_LRCC;
            nextState = cfg.nine ? ST_GAP2 : ST_FIN;
            nextCnt   = '0;
          end else begin
            nextCnt = CW'(cnt + 1'b1);
          end
        end
      end
      ST_GAP2: begin
        if (charEn) begin
          if (gapFull) begin
            strb.emit = 1'b1;
            strb.src  = SRC_LRCC;
            nextState = ST_FIN;
            nextCnt   = '0;
          end else begin
            nextCnt = CW'(cnt + 1'b1);
          end
        end
      end
      ST_FIN: begin
        if (charEn) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cfg      <= '0;
      dataFlag <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      done  <= (state == ST_FIN) && charEn;
      if (strb.startRec) begin
        cfg.nine    <= nineTrack;
        cfg.oddSel  <= nineTrack | oddParity7;
        cfg.special <= specialMark9;
        cfg.mark    <= ~startWrite;
      end
      if (strb.startRec && startWrite) dataFlag <= ~hostHalt;
      else if (hostHalt)               dataFlag <= 1'b0;
      else if (strb.loadHold)          dataFlag <= 1'b0;
      else if (strb.emit && strb.src == SRC_DATA) dataFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/tapefmt_dp.sv
`timescale 1ns/1ps
module tapefmt_dp
  import tapefmt_pkg::*;
#(
  parameter int          CHANS     = 8,
  parameter int          UNUSED7   = 2,
  parameter logic [CHANS:0] CRC_POLY = 9'h079,
  parameter logic [CHANS:0] CRC_INV  = 9'h1EB
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  recCfg_t          cfg,
  input  logic [CHANS-1:0] hostData,
  output logic             holdFull,
  output logic [CHANS-1:0] writeDataN,
  output logic             writeParN,
  output logic             writeStrobe
);

  localparam int VW = CHANS + 1;
  localparam logic [CHANS-1:0] MARK_NINE  = CHANS'((1 << 3) | (1 << 6) | (1 << 7));
  localparam logic [CHANS-1:0] MARK_SEVEN = CHANS'((1 << 4) | (1 << 5) | (1 << 6) | (1 << 7));

  logic [CHANS-1:0] hold;
  logic [CHANS-1:0] dataBits;
  logic [CHANS-1:0] charBits;
  logic [VW-1:0]    charVec;
  logic [VW-1:0]    crcReg, lrcReg, crcT, crcNext;
  logic [VW-1:0]    selVec;
  logic [VW-1:0]    outVec;

  for (genvar k = 0; k < CHANS; k++) begin : g_chan
    if (k < UNUSED7) begin : g_low
      assign dataBits[k] = cfg.nine & hold[CHANS-1-k];
    end else begin : g_high
      assign dataBits[k] = hold[CHANS-1-k];
    end
  end

  always_comb begin
    if (cfg.mark) charBits = (cfg.nine && !cfg.special) ? MARK_NINE : MARK_SEVEN;
    else          charBits = dataBits;
    charVec = {(^charBits) ^ cfg.oddSel, charBits};
  end

  always_comb begin
    crcT    = crcReg ^ charVec;
    crcNext = {crcT[VW-2:0], 1'b0} ^ (crcT[VW-1] ? CRC_POLY : '0);
  end

  always_comb begin
    unique case (strb.src)
      SRC_CRCC: selVec = cfg.mark ? '0 : (crcReg ^ CRC_INV);
      SRC_LRCC: selVec = lrcReg;
      default:  selVec = charVec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hold        <= '0;
      holdFull    <= 1'b0;
      crcReg      <= '0;
      lrcReg      <= '0;
      outVec      <= '0;
      writeStrobe <= 1'b0;
    end else begin
      writeStrobe <= strb.emit;
      if (strb.startRec) begin
        holdFull <= 1'b0;
        crcReg   <= '0;
        lrcReg   <= '0;
      end
      if (strb.emit) begin
        outVec <= selVec;
        if (strb.src == SRC_DATA) holdFull <= 1'b0;
        if (strb.src == SRC_DATA || strb.src == SRC_MARK) crcReg <= crcNext;
        if (strb.src != SRC_LRCC) lrcReg <= lrcReg ^ selVec;
      end
      if (strb.loadHold) begin
        hold     <= hostData;
        holdFull <= 1'b1;
      end
    end
  end

  assign writeDataN = ~outVec[CHANS-1:0];
  assign writeParN  = ~outVec[VW-1];

endmodule

// File: rtl/tapefmt_writer.sv
`timescale 1ns/1ps
module tapefmt_writer
  import tapefmt_pkg::*;
#(
  parameter int GAP_CHARS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       charEn,
  input  logic       nineTrack,
  input  logic       oddParity7,
  input  logic       specialMark9,
  input  logic       startWrite,
  input  logic       startMark,
  output logic       dataFlag,
  input  logic       hostAck,
  input  logic [7:0] hostData,
  input  logic       hostHalt,
  output logic [7:0] writeDataN,
  output logic       writeParN,
  output logic       writeStrobe,
  output logic       done
);

  ctrlStrobe_t strb;
  recCfg_t     cfg;
  logic        holdFull;

  tapefmt_ctrl #(.GAP_CHARS(GAP_CHARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .charEn(charEn),
    .nineTrack(nineTrack), .oddParity7(oddParity7), .specialMark9(specialMark9),
    .startWrite(startWrite), .startMark(startMark),
    .hostAck(hostAck), .hostHalt(hostHalt), .holdFull(holdFull),
    .dataFlag(dataFlag), .done(done), .strb(strb), .cfg(cfg)
  );

  tapefmt_dp #(.CHANS(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .hostData(hostData),
    .holdFull(holdFull), .writeDataN(writeDataN), .writeParN(writeParN),
    .writeStrobe(writeStrobe)
  );

endmodule

// File: rtl/tapefmt_writer_chk.sv
`timescale 1ns/1ps
module tapefmt_writer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       charEn,
  input logic       hostAck,
  input logic       hostHalt,
  input logic       dataFlag,
  input logic       writeStrobe,
  input logic       done,
  input logic [7:0] writeDataN,
  input logic       writeParN,
  input logic       emitNineData
);

  assert_strobe_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    writeStrobe |-> $past(charEn));

  assert_ack_clears_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataFlag && hostAck) |=> !dataFlag);

  assert_halt_blocks_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    hostHalt |=> !dataFlag);

  assert_done_after_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(charEn) && !writeStrobe));

  assert_odd_parity_nine_R2: assert property (@(posedge clk) disable iff (!rstN)
    (writeStrobe && $past(emitNineData)) |-> (^(~{writeParN, writeDataN}) == 1'b1));

endmodule

bind tapefmt_writer tapefmt_writer_chk chk (
  .clk(clk), .rstN(rstN), .charEn(charEn), .hostAck(hostAck), .hostHalt(hostHalt),
  .dataFlag(dataFlag), .writeStrobe(writeStrobe), .done(done),
  .writeDataN(writeDataN), .writeParN(writeParN),
  .emitNineData(strb.emit && (strb.src == tapefmt_pkg::SRC_DATA) && cfg.nine)
);

// File: tb/tapefmt_writer_test.sv
`timescale 1ns/1ps
module tapefmt_writer_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, charEn, nineTrack, oddParity7, specialMark9, startWrite, startMark;
  logic hostAck, hostHalt;
  logic [7:0] hostData;
  logic dataFlag, writeParN, writeStrobe, done;
  logic [7:0] writeDataN;

  tapefmt_writer uut (
    .clk(clk), .rstN(rstN), .charEn(charEn), .nineTrack(nineTrack),
    .oddParity7(oddParity7), .specialMark9(specialMark9),
    .startWrite(startWrite), .startMark(startMark), .dataFlag(dataFlag),
    .hostAck(hostAck), .hostData(hostData), .hostHalt(hostHalt),
    .writeDataN(writeDataN), .writeParN(writeParN),
    .writeStrobe(writeStrobe), .done(done)
  );

  int total = 0;
  int bad = 0;
  int tick = 0;
  int capCount = 0;
  int doneSeen = 0;
  int doneTick = 0;
  logic [8:0] capVec [0:63];
  int capTick [0:63];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] crcStep(input logic [8:0] c, input logic [8:0] v);
    logic [8:0] t;
    t = c ^ v;
    return {t[7:0], 1'b0} ^ (t[8] ? 9'h079 : 9'h000);
  endfunction

  function automatic logic [8:0] chanVec(input logic [7:0] d, input bit nine, input bit oddSel);
    logic [8:0] v;
    for (int k = 0; k < 8; k++) v[k] = d[7-k];
    if (!nine) begin v[0] = 1'b0; v[1] = 1'b0; end
    v[8] = (^v[7:0]) ^ oddSel;
    return v;
  endfunction

  initial begin
    charEn = 1'b0;
    forever begin
      repeat (5) @(negedge clk);
      charEn = 1'b1;
      tick++;
      @(negedge clk);
      charEn = 1'b0;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (writeStrobe && capCount < 64) begin
        capVec[capCount] = {~writeParN, ~writeDataN};
        capTick[capCount] = tick;
        capCount++;
      end
      if (done) begin
        doneTick = tick;
        doneSeen++;
      end
    end
  end

  initial begin
    #(5 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic waitFlag();
    int w = 0;
    while (!dataFlag && w < 200) begin @(negedge clk); w++; end
  endtask

  task automatic runRecord(input bit nine, input bit odd7, input bit spec, input bit mark,
                           input int n, input int seed, input bit haltEarly, input bit poke);
    logic [7:0] d [0:31];
    logic [8:0] expVec [0:63];
    int expTick [0:63];
    string expTag [0:63];
    logic [8:0] crc, lrc, v, xorAll;
    bit oddSel;
    int expN, base, lrcTick, w;
    int unsigned x;
    string tickTag;
    oddSel = nine | odd7;
    tickTag = nine ? "R6" : "R7";
    x = seed;
    for (int i = 0; i < n; i++) begin
      x = x * 1103515245 + 12345;
      d[i] = x[23:16];
    end
    crc = '0; lrc = '0; expN = 0;
    if (mark) begin
      v[7:0] = (nine && !spec) ? 8'hC8 : 8'hF0;
      v[8] = (^v[7:0]) ^ oddSel;
      expVec[0] = v; expTick[0] = 0; expTag[0] = "R10";
      crc = crcStep(crc, v); lrc = lrc ^ v; expN = 1; base = 0;
    end else begin
      for (int i = 0; i < n; i++) begin
        v = chanVec(d[i], nine, oddSel);
        expVec[i] = v; expTick[i] = i; expTag[i] = nine ? "R3" : "R2";
        crc = crcStep(crc, v); lrc = lrc ^ v;
      end
      expN = n; base = n - 1;
    end
    if (nine) begin
      v = mark ? 9'h000 : (crc ^ 9'h1EB);
      expVec[expN] = v; expTick[expN] = base + 5; expTag[expN] = mark ? "R10" : "R9";
      lrc = lrc ^ v; expN++;
      lrcTick = base + 10;
    end else begin
      lrcTick = base + 5;
    end
    expVec[expN] = lrc; expTick[expN] = lrcTick; expTag[expN] = "R8"; expN++;

    capCount = 0; doneSeen = 0;
    nineTrack = nine; oddParity7 = odd7; specialMark9 = spec;
    @(negedge clk);
    if (mark) begin
      startMark = 1'b1; @(negedge clk); startMark = 1'b0;
    end else begin
      startWrite = 1'b1; @(negedge clk); startWrite = 1'b0;
      for (int i = 0; i < n; i++) begin
        waitFlag();
        hostAck = 1'b1; hostData = d[i];
        @(negedge clk);
        hostAck = 1'b0;
        check(dataFlag == 1'b0, "R4 flag cleared by ack", dataFlag, 0);
        if (poke && i == 0) begin
          startWrite = 1'b1; @(negedge clk); startWrite = 1'b0;
        end
        if (haltEarly && i == n - 1) hostHalt = 1'b1;
      end
      if (!haltEarly) begin
        waitFlag();
        check(dataFlag == 1'b1, "R4 flag raised after strobe", dataFlag, 1);
        hostHalt = 1'b1;
      end
      @(negedge clk);
      check(dataFlag == 1'b0, "R5 flag low under halt", dataFlag, 0);
    end
    w = 0;
    while (doneSeen == 0 && w < 600) begin @(negedge clk); w++; end
    hostHalt = 1'b0;
    repeat (8) @(negedge clk);

    check(capCount == expN, poke ? "R12 strobe count" : "R5 strobe count", capCount, expN);
    for (int i = 0; i < expN && i < capCount; i++) begin
      check(capVec[i] == expVec[i], expTag[i], capVec[i], expVec[i]);
      check(capTick[i] - capTick[0] == expTick[i], tickTag, capTick[i] - capTick[0], expTick[i]);
    end
    xorAll = '0;
    for (int i = 0; i < capCount; i++) xorAll ^= capVec[i];
    check(xorAll == 9'h000, "R8 even tracks", xorAll, 0);
    check(doneSeen == 1, "R11 done pulse count", doneSeen, 1);
    if (capCount > 0)
      check(doneTick - capTick[0] == lrcTick + 1, "R11 done timing", doneTick - capTick[0], lrcTick + 1);
  endtask

  initial begin
    rstN = 1'b0; nineTrack = 1'b1; oddParity7 = 1'b1; specialMark9 = 1'b0;
    startWrite = 1'b0; startMark = 1'b0; hostAck = 1'b0; hostHalt = 1'b0; hostData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(dataFlag == 1'b0 && writeStrobe == 1'b0 && done == 1'b0, "R1 controls idle",
          {dataFlag, writeStrobe, done}, 0);
    check({writeParN, writeDataN} == 9'h1FF, "R1 lines high", {writeParN, writeDataN}, 9'h1FF);

    runRecord(1, 0, 0, 0, 1, 11, 0, 0);
    runRecord(1, 0, 0, 0, 2, 23, 1, 0);
    runRecord(1, 0, 0, 0, 5, 37, 0, 1);
    runRecord(1, 0, 0, 0, 16, 41, 0, 0);
    runRecord(0, 1, 0, 0, 1, 53, 0, 0);
    runRecord(0, 1, 0, 0, 8, 67, 1, 0);
    runRecord(0, 0, 0, 0, 3, 71, 0, 0);
    runRecord(0, 0, 0, 0, 12, 83, 0, 1);
    runRecord(1, 0, 0, 1, 0, 1, 0, 0);
    runRecord(1, 0, 1, 1, 0, 1, 0, 0);
    runRecord(0, 1, 0, 1, 0, 1, 0, 0);
    runRecord(0, 0, 0, 1, 0, 1, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule